// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive observer placed beside the command pins of a four-bank SDRAM running at CAS latency 2. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps, for each bank, whether a row is open and how many cycles have passed since that bank last saw an activate, a precharge or a write burst. Across the device it tracks the last activate, the mode-register lockout window and the spacing between auto refreshes. It never drives the bus and stores no data.

A command that breaks a spacing or state rule sets that rule's bit in a sticky error vector. The rule that raised the bit is reported through a one-cycle valid pulse together with a rule code. The violating command is still assumed to take effect, so the bank state keeps following the bus after an error. The bits clear only on reset. The address bit that selects precharge-all is sampled only on precharge commands; auto-precharge on reads and writes is not tracked. Integration is a matter of tapping the command pins and the clock. There is no flow control because the monitor only observes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n high, or with cs_n low and ras_n, cas_n and we_n all high, the cycle carries no command and changes no flag, whatever the other pins carry. With cs_n low, the levels {ras_n,cas_n,we_n} decode as follows: 000 mode set, 001 auto refresh, 011 activate, 010 precharge, 101 read, 100 write, 110 burst stop.
- R2: A read or write to a bank fewer than T_RCD (2) cycles after that bank's activate sets rule code 0.
- R3: An activate fewer than T_RRD (2) cycles after an activate to a different bank sets rule code 1.
- R4: A precharge that reaches a bank fewer than T_RAS (5) cycles after that bank's activate sets rule code 2.
- R5: An activate fewer than T_RC (7) cycles after the previous activate to the same bank sets rule code 3.
- R6: An activate fewer than T_RP (2) cycles after a precharge reached that bank sets rule code 4.
- R7: A mode set or auto refresh issued while any bank is open sets rule code 5.
- R8: Any command other than no-operation fewer than T_MRD (2) cycles after a mode set sets rule code 6. A command exactly T_MRD cycles later is legal.
- R9: A precharge with a10 high closes all four banks and ignores ba. With a10 low it closes only the bank named by ba, and the other banks stay open.
- R10: A precharge to a bank fewer than T_WR (2) cycles after the last data cycle of a write burst to that bank sets rule code 7. Write data starts in the command cycle and lasts BURST_LEN (4) cycles.
- R11: Once the first auto refresh has been seen, a gap of more than REFI_MAX (780) cycles since the previous refresh sets rule code 8 in the cycle the gap reaches REFI_MAX+1. Before the first refresh no such rule applies.
- R12: A read or write to a closed bank sets rule code 9. An activate to a bank that is already open sets rule code 10.
- R13: Bit k of err_flags is rule code k. Bits are sticky until reset. Every cycle in which a command breaks at least one rule is followed by exactly one cycle of err_valid high, with err_code holding the lowest rule code broken. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Precharge-all select, sampled on precharge only |
| err_flags | output | 11 | Sticky violation bits, one per rule code |
| err_valid | output | 1 | One-cycle pulse after a violating command |
| err_code | output | 4 | Lowest rule code broken in the flagged cycle |

## Verification
The bench builds the monitor with its default parameters: four banks, 2/2/5/7/2/2/2-cycle spacings, a four-beat write burst and a 780-cycle refresh limit. With these spacings every rule can be reached within a handful of commands, and the refresh rule can still be crossed in about sixteen hundred cycles, so both the last legal gap of 780 and the first illegal gap of 781 are exercised. Because T_RC equals T_RAS plus T_RP, a same-bank activate that is too early can only break T_RC together with another rule. The bench therefore checks that the reported code is the lower one.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_MRS,
    CMD_REF,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_BST
  } cmd_e;

  localparam int NRULE  = 11;
  localparam int CODE_W = $clog2(NRULE);

  typedef enum logic [CODE_W-1:0] {
    RULE_RCD    = 4'd0,
    RULE_RRD    = 4'd1,
    RULE_RAS    = 4'd2,
    RULE_RC     = 4'd3,
    RULE_RP     = 4'd4,
    RULE_BUSY   = 4'd5,
    RULE_MRD    = 4'd6,
    RULE_WR     = 4'd7,
    RULE_REFI   = 4'd8,
    RULE_CLOSED = 4'd9,
    RULE_REOPEN = 4'd10
  } rule_e;

  typedef struct packed {
    logic rcd;
    logic ras;
    logic rc;
    logic rp;
    logic wr;
    logic closed;
    logic reopen;
  } bank_viol_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_guard_cnt.sv
module sdram_guard_cnt #(
  parameter int SPAN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int W = (SPAN < 2) ? 1 : $clog2(SPAN + 1);
  localparam logic [W-1:0] LOAD_VAL = W'(SPAN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int T_RP      = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       sel,
  input  logic       pre_sel,
  output logic       is_open,
  output bank_viol_t viol
);

  localparam int WR_SPAN = BURST_LEN - 1 + T_WR;

  logic act_hit, pre_hit, wr_hit, rw_hit;
  logic rcd_busy, ras_busy, rc_busy, rp_busy, wr_busy;
  logic open_q;

  assign act_hit = (cmd == CMD_ACT) && sel;
  assign pre_hit = (cmd == CMD_PRE) && pre_sel;
  assign wr_hit  = (cmd == CMD_WR)  && sel;
  assign rw_hit  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;

  sdram_guard_cnt #(.SPAN(T_RCD))   u_rcd (.clk(clk), .rst_n(rst_n), .load(act_hit), .busy(rcd_busy));
  sdram_guard_cnt #(.SPAN(T_RAS))   u_ras (.clk(clk), .rst_n(rst_n), .load(act_hit), .busy(ras_busy));
  sdram_guard_cnt #(.SPAN(T_RC))    u_rc  (.clk(clk), .rst_n(rst_n), .load(act_hit), .busy(rc_busy));
  sdram_guard_cnt #(.SPAN(T_RP))    u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_hit), .busy(rp_busy));
  sdram_guard_cnt #(.SPAN(WR_SPAN)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_hit),  .busy(wr_busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (act_hit) begin
      open_q <= 1'b1;
    end else if (pre_hit) begin
      open_q <= 1'b0;
    end
  end

  always_comb begin
    viol.rcd    = rw_hit  && rcd_busy;
    viol.closed = rw_hit  && !open_q;
    viol.ras    = pre_hit && ras_busy;
    viol.wr     = pre_hit && wr_busy;
    viol.rc     = act_hit && rc_busy;
    viol.rp     = act_hit && rp_busy;
    viol.reopen = act_hit && open_q;
  end

  assign is_open = open_q;

endmodule

// File: rtl/sdram_global_track.sv
module sdram_global_track
  import sdram_mon_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int T_RRD    = 2,
  parameter int T_MRD    = 2,
  parameter int REFI_MAX = 780
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            any_open,
  output logic            v_rrd,
  output logic            v_busy,
  output logic            v_mrd,
  output logic            v_refi
);

  localparam int RW = $clog2(REFI_MAX + 3);
  localparam logic [RW-1:0] REFI_HIT = RW'(REFI_MAX + 1);

  logic            is_act, is_mrs, is_ref;
  logic            rrd_busy, mrd_busy;
  logic [BA_W-1:0] last_bank_q;
  logic [RW-1:0]   refi_q;
  logic            refi_on_q;

  assign is_act = (cmd == CMD_ACT);
  assign is_mrs = (cmd == CMD_MRS);
  assign is_ref = (cmd == CMD_REF);

  sdram_guard_cnt #(.SPAN(T_RRD)) u_rrd (.clk(clk), .rst_n(rst_n), .load(is_act), .busy(rrd_busy));
  sdram_guard_cnt #(.SPAN(T_MRD)) u_mrd (.clk(clk), .rst_n(rst_n), .load(is_mrs), .busy(mrd_busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_bank_q <= '0;
    end else if (is_act) begin
      last_bank_q <= ba;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refi_on_q <= 1'b0;
      refi_q    <= '0;
    end else if (is_ref) begin
      refi_on_q <= 1'b1;
      refi_q    <= RW'(1);
    end else if (refi_on_q && (refi_q <= REFI_HIT)) begin
      refi_q    <= refi_q + 1'b1;
    end
  end

  assign v_rrd  = is_act && rrd_busy && (ba != last_bank_q);
  assign v_busy = (is_mrs || is_ref) && any_open;
  assign v_mrd  = (cmd != CMD_NOP) && mrd_busy;
  assign v_refi = refi_on_q && (refi_q == REFI_HIT);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int T_RCD     = 2,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int T_RP      = 2,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int REFI_MAX  = 780,
  localparam int BA_W     = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  output logic [NRULE-1:0]  err_flags,
  output logic              err_valid,
  output logic [CODE_W-1:0] err_code
);

  cmd_e             cmd;
  bank_viol_t       bviol [NBANK];
  logic [NBANK-1:0] open_vec;
  logic             v_rrd, v_busy, v_mrd, v_refi;
  logic [NRULE-1:0] hits;
  logic [CODE_W-1:0] first_code;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(b));
    sdram_bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
      .T_WR(T_WR), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(sel),
      .pre_sel(sel | a10), .is_open(open_vec[b]), .viol(bviol[b])
    );
  end

  sdram_global_track #(
    .BA_W(BA_W), .T_RRD(T_RRD), .T_MRD(T_MRD), .REFI_MAX(REFI_MAX)
  ) u_glob (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .any_open(|open_vec),
    .v_rrd(v_rrd), .v_busy(v_busy), .v_mrd(v_mrd), .v_refi(v_refi)
  );

  always_comb begin
    hits = '0;
    hits[RULE_RRD]  = v_rrd;
    hits[RULE_BUSY] = v_busy;
    hits[RULE_MRD]  = v_mrd;
    hits[RULE_REFI] = v_refi;
    for (int b = 0; b < NBANK; b++) begin
      hits[RULE_RCD]    = hits[RULE_RCD]    | bviol[b].rcd;
      hits[RULE_RAS]    = hits[RULE_RAS]    | bviol[b].ras;
      hits[RULE_RC]     = hits[RULE_RC]     | bviol[b].rc;
      hits[RULE_RP]     = hits[RULE_RP]     | bviol[b].rp;
      hits[RULE_WR]     = hits[RULE_WR]     | bviol[b].wr;
      hits[RULE_CLOSED] = hits[RULE_CLOSED] | bviol[b].closed;
      hits[RULE_REOPEN] = hits[RULE_REOPEN] | bviol[b].reopen;
    end
  end

  always_comb begin
    first_code = '0;
    for (int r = NRULE - 1; r >= 0; r--) begin
      if (hits[r]) first_code = CODE_W'(r);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_valid <= 1'b0;
      err_code  <= '0;
    end else begin
      err_flags <= err_flags | hits;
      err_valid <= |hits;
      err_code  <= first_code;
    end
  end

endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker
  import sdram_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [NRULE-1:0]  err_flags,
  input logic              err_valid,
  input logic [CODE_W-1:0] err_code
);

  logic armed;
  logic is_mrs, is_act, is_rw, non_nop;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_act  = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_rw   = !cs_n &&  ras_n && !cas_n;
  assign non_nop = !cs_n && !(ras_n && cas_n && we_n);

  // R13: flags never fall while out of reset
  assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(err_flags) & ~err_flags) == '0));

  // R13: a newly raised flag is announced by the valid pulse
  assert_new_flag_pulses_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (err_flags != $past(err_flags))) |-> err_valid);

  // R13: the reported code names a raised flag
  assert_code_flagged_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> err_flags[err_code]);

  // R8: a command right after a mode set is caught
  assert_mrd_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(is_mrs) && non_nop) |=> err_flags[RULE_MRD]);

  // R3: back-to-back activates on different banks are caught
  assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(is_act) && is_act && (ba != $past(ba))) |=> err_flags[RULE_RRD]);

  // R2: column command one cycle after its activate is caught
  assert_col_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(is_act) && is_rw && (ba == $past(ba))) |=> err_flags[RULE_RCD]);

endmodule

bind sdram_cmd_monitor sdram_mon_checker #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .err_flags(err_flags), .err_valid(err_valid),
  .err_code(err_code)
);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;

  localparam int NR = 11;
  localparam int BL = 4;
  localparam int REFI = 780;
  localparam int FAR = -100000;

  localparam int C_NOP = 0, C_MRS = 1, C_REF = 2, C_ACT = 3, C_PRE = 4,
                 C_RD = 5, C_WR = 6, C_BST = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [NR-1:0] err_flags;
  logic err_valid;
  logic [3:0] err_code;

  int n_tests = 0;
  int n_fail = 0;

  sdram_cmd_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_flags(err_flags),
    .err_valid(err_valid), .err_code(err_code)
  );

  always #10 clk = ~clk;

  // reference model state: absolute times of events
  int cyc;
  int act_t[4], pre_t[4], wr_end[4];
  bit open_m[4];
  int last_act, last_bank, mrs_t, ref_t;
  bit ref_on;
  logic [NR-1:0] exp_flags;
  bit exp_valid;
  int exp_code;

  function automatic void model_reset();
    cyc = 0;
    for (int b = 0; b < 4; b++) begin
      act_t[b] = FAR; pre_t[b] = FAR; wr_end[b] = FAR; open_m[b] = 0;
    end
    last_act = FAR; last_bank = 0; mrs_t = FAR; ref_t = FAR; ref_on = 0;
    exp_flags = '0; exp_valid = 0; exp_code = 0;
  endfunction

  function automatic int decode(bit c, bit r, bit k, bit w);
    if (c) return C_NOP;
    case ({r, k, w})
      3'b000: return C_MRS;
      3'b001: return C_REF;
      3'b011: return C_ACT;
      3'b010: return C_PRE;
      3'b101: return C_RD;
      3'b100: return C_WR;
      3'b110: return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  function automatic void model_step(int c, int b, bit all);
    logic [NR-1:0] h = '0;
    bit any_open = open_m[0] | open_m[1] | open_m[2] | open_m[3];
    if ((c == C_RD || c == C_WR)) begin
      if (cyc - act_t[b] < 2) h[0] = 1;
      if (!open_m[b]) h[9] = 1;
    end
    if (c == C_ACT) begin
      if (b != last_bank && cyc - last_act < 2) h[1] = 1;
      if (cyc - act_t[b] < 7) h[3] = 1;
      if (cyc - pre_t[b] < 2) h[4] = 1;
      if (open_m[b]) h[10] = 1;
    end
    if (c == C_PRE) begin
      for (int k = 0; k < 4; k++) begin
        if (all || k == b) begin
          if (cyc - act_t[k] < 5) h[2] = 1;
          if (cyc - wr_end[k] < 2) h[7] = 1;
        end
      end
    end
    if ((c == C_MRS || c == C_REF) && any_open) h[5] = 1;
    if (c != C_NOP && cyc - mrs_t < 2) h[6] = 1;
    if (ref_on && cyc - ref_t == REFI + 1) h[8] = 1;

    exp_flags = exp_flags | h;
    exp_valid = (h != '0);
    if (exp_valid) begin
      for (int r = NR - 1; r >= 0; r--) if (h[r]) exp_code = r;
    end

    case (c)
      C_ACT: begin open_m[b] = 1; act_t[b] = cyc; last_act = cyc; last_bank = b; end
      C_PRE: for (int k = 0; k < 4; k++) if (all || k == b) begin open_m[k] = 0; pre_t[k] = cyc; end
      C_WR:  wr_end[b] = cyc + BL - 1;
      C_MRS: mrs_t = cyc;
      C_REF: begin ref_t = cyc; ref_on = 1; end
      default: ;
    endcase
    cyc++;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    n_tests++;
    if (err_flags !== exp_flags || err_valid !== exp_valid ||
        (exp_valid && err_code !== 4'(exp_code))) begin
      n_fail++;
      $display("FAIL R13 cycle %0d actual flags=%h valid=%0d code=%0d expected flags=%h valid=%0d code=%0d",
               cyc, err_flags, err_valid, err_code, exp_flags, exp_valid, exp_code);
    end
  endtask

  // drives pins at negedge, model advances, compares at next negedge
  task automatic pins(bit c, bit r, bit k, bit w, int b, bit all);
    cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = 2'(b); a10 = all;
    model_step(decode(c, r, k, w), b, all);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(int c, int b = 0, bit all = 0);
    case (c)
      C_MRS: pins(0, 0, 0, 0, b, all);
      C_REF: pins(0, 0, 0, 1, b, all);
      C_ACT: pins(0, 0, 1, 1, b, all);
      C_PRE: pins(0, 0, 1, 0, b, all);
      C_RD:  pins(0, 1, 0, 1, b, all);
      C_WR:  pins(0, 1, 0, 0, b, all);
      C_BST: pins(0, 1, 1, 0, b, all);
      default: pins(0, 1, 1, 1, b, all);
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cmd(C_NOP);
  endtask

  task automatic do_reset();
    rst_n = 0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = '0; a10 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    check("R13 reset flags", int'(err_flags), 0);
    check("R13 reset valid", int'(err_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: deselected cycles with command-like pins do nothing
    do_reset();
    pins(1, 0, 0, 0, 0, 0);
    pins(1, 0, 1, 1, 2, 0);
    cmd(C_ACT, 0);
    pins(1, 0, 1, 1, 1, 0);
    pins(1, 0, 1, 1, 0, 0);
    idle(2);
    check("R1 deselect ignored", int'(err_flags), 0);

    // R2: read right after activate; legal write at spacing 2
    do_reset();
    cmd(C_ACT, 0); cmd(C_RD, 0);
    check("R2 rcd flag", int'(err_flags[0]), 1);
    check("R2 code", int'(err_code), 0);
    do_reset();
    cmd(C_ACT, 2); cmd(C_NOP); cmd(C_WR, 2);
    check("R2 legal write", int'(err_flags), 0);

    // R3
    do_reset();
    cmd(C_ACT, 0); cmd(C_ACT, 1);
    check("R3 rrd flag", int'(err_flags[1]), 1);
    do_reset();
    cmd(C_ACT, 0); cmd(C_NOP); cmd(C_ACT, 1);
    check("R3 legal spacing", int'(err_flags), 0);

    // R4
    do_reset();
    cmd(C_ACT, 2); idle(2); cmd(C_PRE, 2);
    check("R4 ras flag", int'(err_flags[2]), 1);

    // R5 and R12: early reopen on same bank, code picks lower rule
    do_reset();
    cmd(C_ACT, 0); idle(2); cmd(C_ACT, 0);
    check("R5 rc flag", int'(err_flags[3]), 1);
    check("R12 reopen flag", int'(err_flags[10]), 1);
    check("R5 lowest code", int'(err_code), 3);
    cmd(C_NOP);
    check("R13 pulse one cycle", int'(err_valid), 0);
    check("R13 flag sticky", int'(err_flags[3]), 1);

    // R6
    do_reset();
    cmd(C_ACT, 0); idle(5); cmd(C_PRE, 0); cmd(C_ACT, 0);
    check("R6 rp flag", int'(err_flags[4]), 1);
    check("R6 only rp", int'(err_flags), 16);

    // R7
    do_reset();
    cmd(C_ACT, 0); cmd(C_NOP); cmd(C_REF);
    check("R7 refresh while open", int'(err_flags[5]), 1);
    do_reset();
    cmd(C_ACT, 1); idle(8); cmd(C_MRS);
    check("R7 mode set while open", int'(err_flags[5]), 1);

    // R8
    do_reset();
    cmd(C_MRS); cmd(C_ACT, 0);
    check("R8 mrd flag", int'(err_flags[6]), 1);
    do_reset();
    cmd(C_MRS); cmd(C_NOP); cmd(C_ACT, 0);
    check("R8 legal after lockout", int'(err_flags), 0);

    // R9: precharge-all ignores ba
    do_reset();
    cmd(C_ACT, 1); cmd(C_NOP); cmd(C_ACT, 2); idle(6);
    cmd(C_PRE, 0, 1); idle(2); cmd(C_REF);
    check("R9 all closed", int'(err_flags), 0);
    cmd(C_NOP); cmd(C_RD, 2);
    check("R9 bank2 closed by all", int'(err_flags[9]), 1);
    // R9: single precharge leaves others open
    do_reset();
    cmd(C_ACT, 1); cmd(C_NOP); cmd(C_ACT, 2); idle(6);
    cmd(C_PRE, 1, 0); cmd(C_NOP); cmd(C_RD, 2);
    check("R9 bank2 still open", int'(err_flags), 0);
    cmd(C_RD, 1);
    check("R9 bank1 closed", int'(err_flags[9]), 1);

    // R10
    do_reset();
    cmd(C_ACT, 3); cmd(C_NOP); cmd(C_WR, 3); idle(3); cmd(C_PRE, 3);
    check("R10 write recovery flag", int'(err_flags[7]), 1);
    do_reset();
    cmd(C_ACT, 3); cmd(C_NOP); cmd(C_WR, 3); idle(4); cmd(C_PRE, 3);
    check("R10 legal recovery", int'(err_flags), 0);

    // R12
    do_reset();
    cmd(C_RD, 0);
    check("R12 read closed", int'(err_flags[9]), 1);
    check("R12 code", int'(err_code), 9);

    // R11
    do_reset();
    idle(REFI + 20);
    check("R11 no rule before first refresh", int'(err_flags), 0);
    cmd(C_REF); idle(REFI - 1); cmd(C_REF);
    check("R11 gap of limit legal", int'(err_flags), 0);
    idle(REFI);
    check("R11 still clean", int'(err_flags), 0);
    cmd(C_NOP);
    check("R11 refi flag", int'(err_flags[8]), 1);
    check("R11 code", int'(err_code), 8);

    // R13: reset clears
    do_reset();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule